// File: doc/BRIEF.md
# SIMD Lane Predication Enable Stack

This block holds the predication state for a SIMD array of `LANES` lanes. It lets nested conditionals run without branching: each lane is masked instead of jumping. Every lane owns a fixed-depth stack of enable bits, and a lane is active only while every bit on its stack is 1. A broadcast control opcode runs in every lane on the same cycle. A conditional test pushes that lane's comparison result. An inversion flips only the innermost condition. A close pops the innermost condition and so brings back the enable state the lane had before the matching test. Conditional-control opcodes are never masked, so disabled lanes still push, flip and pop.

The stack pointer is common to all lanes, because every lane sees the same opcode stream. A small controller state machine tracks the pointer through three named states: `S_EMPTY` (no conditions open), `S_NEST` (one or more open, room left) and `S_FULL` (every slot in use). The transitions are push (`S_EMPTY`→`S_NEST`, `S_NEST`→`S_NEST` or `S_FULL`), pop (`S_FULL`→`S_NEST`, `S_NEST`→`S_NEST` or `S_EMPTY`) and clear (any state →`S_EMPTY`). An inversion keeps the state it finds. A push in `S_FULL`, or an inversion or pop in `S_EMPTY`, is rejected. It sets a sticky error flag and leaves all stacks untouched. The per-lane enable is registered. A write-enable output adds a force request, so that forced loads and stores reach disabled lanes.

Top module: `lane_pred_stack`

## Requirements
- R1: After reset the stack depth is 0, every lane's `lane_en` is 1 and `stack_err` is 0. Whenever the depth is 0, every lane is enabled.
- R2: Opcode 3'd1 (conditional test) with `op_valid` pushes `cond[i]` onto lane i's stack and raises the depth by 1. From the next cycle, lane i is enabled only if it was enabled before and `cond[i]` is 1.
- R3: Opcode 3'd2 (invert) flips only the top bit of every lane's stack. The depth and the lower bits are unchanged.
- R4: Opcode 3'd3 (close) pops the top bit in every lane and lowers the depth by 1. Each lane returns to its enable state from before the matching push.
- R5: Opcode 3'd4 (open unconditionally) pushes a 1 in every lane. The enables do not change and the depth rises by 1.
- R6: Opcode 3'd5 (clear) empties all stacks: the depth becomes 0 and every lane is enabled. `stack_err` is not changed.
- R7: A push (3'd1 or 3'd4) when the depth equals `DEPTH` (8) sets `stack_err` and leaves the depth and all enables unchanged.
- R8: An invert or close when the depth is 0 sets `stack_err` and leaves the depth and all enables unchanged.
- R9: Once set, `stack_err` stays at 1 until `rst_n` is asserted.
- R10: `lane_wr_en[i]` is `lane_en[i]` OR `force_req`. When `force_req` is 1, every lane is write-enabled.
- R11: With `op_valid` low, or with opcode 3'd0, 3'd6 or 3'd7, the stack, the depth and the enables do not change.
- R12: Stack operations run in disabled lanes too. A lane disabled by an outer condition still records inner pushes and inversions, so a later pop restores it correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A broadcast control opcode is present |
| op_code | input | 3 | Control opcode (0 none, 1 test, 2 invert, 3 close, 4 open, 5 clear) |
| cond | input | LANES | Per-lane comparison result for a test |
| force_req | input | 1 | Forced load/store in progress |
| lane_en | output | LANES | Registered per-lane enable |
| lane_wr_en | output | LANES | Per-lane state-write enable including the force override |
| stack_err | output | 1 | Sticky overflow/underflow flag |
| depth_o | output | $clog2(DEPTH+1) | Current number of stacked conditions |

## Verification
The checker watches a set of rules on every cycle. It confirms that the depth never passes `DEPTH`, that an empty stack means all lanes are enabled, and that the error flag never drops. It also checks that a rejected push or pop freezes the depth, that a test never re-enables a lane, and that an unconditional open, an idle cycle or a clear has its stated effect on the enables. The write enable must never be active in a disabled lane unless a force is present. Only the bench's scenarios can show the exact per-lane bit sequence. That means an inversion restores the outer masking, and a close returns each lane to its earlier state after nesting through disabled lanes. These scenarios are compared against a level-by-level reference model.

// File: rtl/lane_pred_pkg.sv
package lane_pred_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_TEST  = 3'd1,
        OP_INV   = 3'd2,
        OP_CLOSE = 3'd3,
        OP_OPEN  = 3'd4,
        OP_CLEAR = 3'd5
    } pred_op_e;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_NEST  = 2'd1,
        S_FULL  = 2'd2
    } depth_state_e;
endpackage

// File: rtl/pred_ctrl.sv
module pred_ctrl
    import lane_pred_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    output logic          do_push,
    output logic          do_pop,
    output logic          do_inv,
    output logic          do_clr,
    output logic          push_one,
    output logic [PW-1:0] ptr,
    output logic          err
);
    localparam logic [PW-1:0] FULL_PTR = PW'(DEPTH);

    depth_state_e state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic          err_q, bad_op;

    // decode the broadcast opcode against the current state
    always_comb begin
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_inv   = 1'b0;
        do_clr   = 1'b0;
        push_one = 1'b0;
        bad_op   = 1'b0;
        if (op_valid) begin
            unique case (op_code)
                OP_TEST, OP_OPEN: begin
                    if (state_q == S_FULL) bad_op = 1'b1;
                    else begin
                        do_push  = 1'b1;
                        push_one = (op_code == OP_OPEN);
                    end
                end
                OP_INV: begin
                    if (state_q == S_EMPTY) bad_op = 1'b1;
                    else do_inv = 1'b1;
                end
                OP_CLOSE: begin
                    if (state_q == S_EMPTY) bad_op = 1'b1;
                    else do_pop = 1'b1;
                end
                OP_CLEAR: do_clr = 1'b1;
                default: ;
            endcase
        end
    end

    // next pointer and next state
    always_comb begin
        ptr_d = ptr_q;
        if (do_clr)       ptr_d = '0;
        else if (do_push) ptr_d = ptr_q + 1'b1;
        else if (do_pop)  ptr_d = ptr_q - 1'b1;

        if (ptr_d == '0)            state_d = S_EMPTY;
        else if (ptr_d == FULL_PTR) state_d = S_FULL;
        else                        state_d = S_NEST;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            ptr_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            err_q   <= err_q | bad_op;
        end
    end

    assign ptr = ptr_q;
    assign err = err_q;
endmodule

// File: rtl/pred_lane.sv
module pred_lane #(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_push,
    input  logic          do_pop,
    input  logic          do_inv,
    input  logic          do_clr,
    input  logic          push_one,
    input  logic [PW-1:0] ptr,
    input  logic          cond_bit,
    output logic          en
);
    // unused slots are held at 1 so the enable is a plain AND over all slots
    logic [DEPTH-1:0] stk_q, stk_d;
    logic             en_q;

    always_comb begin
        stk_d = stk_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (do_clr) begin
                stk_d[i] = 1'b1;
            end else if (do_push && ptr == PW'(i)) begin
                stk_d[i] = push_one | cond_bit;
            end else if (do_pop && ptr == PW'(i + 1)) begin
                stk_d[i] = 1'b1;
            end else if (do_inv && ptr == PW'(i + 1)) begin
                stk_d[i] = ~stk_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '1;
            en_q  <= 1'b1;
        end else begin
            stk_q <= stk_d;
            en_q  <= &stk_d;
        end
    end

    assign en = en_q;
endmodule

// File: rtl/lane_pred_stack.sv
module lane_pred_stack #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [LANES-1:0] cond,
    input  logic             force_req,
    output logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] lane_wr_en,
    output logic             stack_err,
    output logic [PW-1:0]    depth_o
);
    logic          do_push, do_pop, do_inv, do_clr, push_one;
    logic [PW-1:0] ptr;

    pred_ctrl #(.DEPTH(DEPTH), .PW(PW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .do_inv   (do_inv),
        .do_clr   (do_clr),
        .push_one (push_one),
        .ptr      (ptr),
        .err      (stack_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pred_lane #(.DEPTH(DEPTH), .PW(PW)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_push  (do_push),
            .do_pop   (do_pop),
            .do_inv   (do_inv),
            .do_clr   (do_clr),
            .push_one (push_one),
            .ptr      (ptr),
            .cond_bit (cond[g]),
            .en       (lane_en[g])
        );
    end

    assign lane_wr_en = lane_en | {LANES{force_req}};
    assign depth_o    = ptr;
endmodule

// File: rtl/lane_pred_stack_chk.sv
module lane_pred_stack_chk
    import lane_pred_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             force_req,
    input logic [LANES-1:0] lane_en,
    input logic [LANES-1:0] lane_wr_en,
    input logic             stack_err,
    input logic [PW-1:0]    depth_o
);
    localparam logic [PW-1:0] FULL_PTR = PW'(DEPTH);

    logic is_push, is_pop;
    assign is_push = op_valid && (op_code == OP_TEST || op_code == OP_OPEN);
    assign is_pop  = op_valid && (op_code == OP_INV || op_code == OP_CLOSE);

    a_r1_empty_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == '0) |-> (lane_en == '1));

    a_r2_test_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TEST && depth_o != FULL_PTR)
        |=> ((lane_en & ~$past(lane_en)) == '0));

    a_r4_close_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLOSE && depth_o != '0)
        |=> (depth_o == $past(depth_o) - 1'b1));

    a_r5_open_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_OPEN && depth_o != FULL_PTR)
        |=> $stable(lane_en));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLEAR) |=> (depth_o == '0 && lane_en == '1));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= FULL_PTR);

    a_r7_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && depth_o == FULL_PTR) |=> (stack_err && $stable(depth_o) && $stable(lane_en)));

    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && depth_o == '0) |=> (stack_err && depth_o == '0));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

    a_r10_force_all: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |-> (lane_wr_en == '1));

    a_r10_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
        !force_req |-> ((lane_wr_en & ~lane_en) == '0));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(depth_o) && $stable(lane_en)));
endmodule

bind lane_pred_stack lane_pred_stack_chk #(.LANES(LANES), .DEPTH(DEPTH), .PW(PW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .force_req  (force_req),
    .lane_en    (lane_en),
    .lane_wr_en (lane_wr_en),
    .stack_err  (stack_err),
    .depth_o    (depth_o)
);

// File: tb/lane_pred_stack_tb_top.sv
module lane_pred_stack_tb_top;
    localparam int LANES = 8;
    localparam int DEPTH = 8;
    localparam int PW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             op_valid;
    logic [2:0]       op_code;
    logic [LANES-1:0] cond;
    logic             force_req;
    logic [LANES-1:0] lane_en, lane_wr_en;
    logic             stack_err;
    logic [PW-1:0]    depth_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // reference model: one lane vector per stack level
    logic [LANES-1:0] m_lvl [DEPTH];
    int               m_d;
    logic             m_err;

    always #2.5 clk = ~clk;

    lane_pred_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .cond       (cond),
        .force_req  (force_req),
        .lane_en    (lane_en),
        .lane_wr_en (lane_wr_en),
        .stack_err  (stack_err),
        .depth_o    (depth_o)
    );

    function automatic logic [LANES-1:0] exp_en();
        logic [LANES-1:0] e = '1;
        for (int k = 0; k < m_d; k++) e &= m_lvl[k];
        return e;
    endfunction

    function automatic void model_op(logic v, logic [2:0] c, logic [LANES-1:0] cb);
        if (!v) return;
        case (c)
            3'd1, 3'd4: if (m_d == DEPTH) m_err = 1'b1;
                        else begin m_lvl[m_d] = (c == 3'd4) ? '1 : cb; m_d++; end
            3'd2: if (m_d == 0) m_err = 1'b1; else m_lvl[m_d-1] = ~m_lvl[m_d-1];
            3'd3: if (m_d == 0) m_err = 1'b1; else m_d--;
            3'd5: m_d = 0;
            default: ;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " lane_en"}, 32'(lane_en), 32'(exp_en()));
        check({tag, " depth"}, 32'(depth_o), 32'(m_d));
        check({tag, " err"}, 32'(stack_err), 32'(m_err));
        check({"R10 ", tag, " wr_en"}, 32'(lane_wr_en), 32'(exp_en() | {LANES{force_req}}));
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(string tag, logic v, logic [2:0] c, logic [LANES-1:0] cb, logic f);
        op_valid = v; op_code = c; cond = cb; force_req = f;
        @(posedge clk);
        model_op(v, c, cb);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; cond = '0; force_req = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_d = 0; m_err = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        do_reset();
        check_all("R1 reset");

        // nesting through disabled lanes (R12)
        step("R2 test a5", 1'b1, 3'd1, 8'hA5, 1'b0);
        step("R2 R12 nested test 0f", 1'b1, 3'd1, 8'h0F, 1'b0);
        step("R3 invert", 1'b1, 3'd2, 8'h00, 1'b0);
        step("R4 close inner", 1'b1, 3'd3, 8'h00, 1'b0);
        step("R4 close outer", 1'b1, 3'd3, 8'h00, 1'b0);
        step("R8 close empty", 1'b1, 3'd3, 8'h00, 1'b0);
        step("R9 idle keeps err", 1'b0, 3'd0, 8'h00, 1'b0);
        step("R9 clear keeps err", 1'b1, 3'd5, 8'h00, 1'b0);
        do_reset();
        check_all("R1 R9 reset clears err");
        step("R8 invert empty", 1'b1, 3'd2, 8'h00, 1'b0);
        do_reset();

        // fill, then overflow
        step("R2 test 3c", 1'b1, 3'd1, 8'h3C, 1'b0);
        for (int k = 1; k < DEPTH; k++) step("R5 open", 1'b1, 3'd4, 8'h00, 1'b0);
        step("R7 test when full", 1'b1, 3'd1, 8'hFF, 1'b0);
        step("R7 open when full", 1'b1, 3'd4, 8'h00, 1'b0);
        step("R11 invalid op", 1'b0, 3'd2, 8'h00, 1'b0);
        step("R11 code 6", 1'b1, 3'd6, 8'h00, 1'b0);
        step("R10 force", 1'b0, 3'd0, 8'h00, 1'b1);
        step("R6 clear", 1'b1, 3'd5, 8'h00, 1'b0);
        do_reset();

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] c;
            int r;
            if (n % 400 == 399) do_reset();
            r = $urandom_range(0, 99);
            if (r < 30)      c = 3'd1;
            else if (r < 45) c = 3'd2;
            else if (r < 70) c = 3'd3;
            else if (r < 82) c = 3'd4;
            else if (r < 86) c = 3'd5;
            else             c = 3'($urandom_range(0, 7));
            step("R2-mix random", ($urandom_range(0, 9) != 0), c,
                 LANES'($urandom), ($urandom_range(0, 7) == 0));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule